// File: doc/BRIEF.md
# Switchable CPU Clock Generator

This block runs entirely on a 20.2752 MHz master clock. It derives every slower clock as a one-cycle enable strobe, paired with a square-wave copy for anything that needs a level. A speed select chooses the CPU rate. Fast mode divides the master clock by 5 (4.05504 MHz) and slow mode divides it by 10 (2.02752 MHz). In fast mode, a CPU period that begins while the processor reports an opcode fetch is lengthened by one master cycle, which gives a divide ratio of 6.

A fixed divide-by-4 reference is provided for an external serial baud generator. A pixel shift-clock enable is also produced. It comes either from an internal divide-by-2 of the master clock (about 10 MHz) or from an external 12.672 MHz source. That source is supplied as a strobe that is already synchronous to the master clock; the 80-column text mode uses it.

The CPU period length and the pixel source are changed only at safe points, so no shortened pulse is ever emitted. Reset is synchronous and active high. It clears every divider and starts the CPU clock in slow mode.

Top module: `cpuclk_gen`

## Requirements
- R1: While `rst` is high, every output is low. After reset is released, the CPU runs in slow mode: the first `cpu_ce_o` pulse follows the 10th rising clock edge after release.
- R2: With `fast_sel_i` = 0 (slow), each CPU period lasts 10 master cycles, and `cpu_clk_o` is high for the first 5 of them.
- R3: With `fast_sel_i` = 1 and `fetch_i` = 0, each CPU period lasts 5 master cycles, and `cpu_clk_o` is high for the first 2.
- R4: With `fast_sel_i` = 1 and `fetch_i` = 1, each CPU period lasts 6 master cycles, and `cpu_clk_o` is high for the first 3.
- R5: The length of a CPU period is set only by the values of `fast_sel_i` and `fetch_i` at the clock edge that starts the period, which is the edge that raises `cpu_ce_o`. Changes to these inputs in the middle of a period have no effect on that period.
- R6: `cpu_ce_o` is high for exactly one master cycle per CPU period, and that cycle is the first high cycle of `cpu_clk_o`.
- R7: `ser_ce_o` pulses after every 4th edge following release (edge count n with n mod 4 = 0). `ser_clk_o` is high after edges with n mod 4 in {0, 1} and low otherwise.
- R8: When `pix_src_o` = 0 (internal source), `pix_ce_o` is high after every odd-numbered edge from edge 3 onward and low after even-numbered edges.
- R9: When `pix_src_o` = 1 (external source), `pix_ce_o` after an edge equals the value of `ext_pix_en_i` at that edge.
- R10: `pix_src_o` takes the value of `pix_ext_req_i` only at an edge where the currently selected source delivers a pulse. That pulse still comes out of the old source. At all other edges `pix_src_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20.2752 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_sel_i | input | 1 | 1 = divide by 5 (fast), 0 = divide by 10 (slow) |
| fetch_i | input | 1 | High while the CPU is in an opcode fetch cycle |
| pix_ext_req_i | input | 1 | Requested pixel source: 1 = external 12.672 MHz, 0 = internal divide-by-2 |
| ext_pix_en_i | input | 1 | 12.672 MHz enable strobe, synchronous to clk |
| cpu_clk_o | output | 1 | CPU clock as a square wave (registered) |
| cpu_ce_o | output | 1 | One-cycle strobe at the start of each CPU period |
| ser_clk_o | output | 1 | Serial reference square wave, master / 4 |
| ser_ce_o | output | 1 | Serial reference strobe, master / 4 |
| pix_ce_o | output | 1 | Pixel shift-clock enable from the selected source |
| pix_src_o | output | 1 | Pixel source currently in use |

## Verification
Every output is a single register stage away from the inputs it depends on, so each result can be seen one clock edge after the stimulus that produced it. The bench drives inputs on the falling edge and samples on the next falling edge. This means the inputs it compares against are exactly the values the design saw at the rising edge in between. For the CPU clock, the bench computes the expected period length from the inputs present at the edge that raised `cpu_ce_o`. It then counts falling edges until the next strobe, and counts the high cycles in between. The serial and internal pixel strobes are compared against the edge count since release. The external pixel path and the source switch are compared against a one-cycle-delayed model of the selection.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

  typedef enum logic {
    SPEED_SLOW = 1'b0,
    SPEED_FAST = 1'b1
  } speed_e;

  typedef enum logic {
    PIXSRC_INT = 1'b0,
    PIXSRC_EXT = 1'b1
  } pixsrc_e;

endpackage

// File: rtl/fixed_div.sv
module fixed_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic ce_o,
  output logic sq_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HI   = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    if (cnt_q == LAST) cnt_n = '0;
    else               cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ce_o  <= 1'b0;
      sq_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ce_o  <= (cnt_n == '0);
      sq_o  <= (cnt_n < HI);
    end
  end

  AST_FDIV_CE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ce_o |=> !ce_o); // R7
  AST_FDIV_CE_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
    ce_o |-> sq_o); // R7

endmodule

// File: rtl/cpu_div.sv
module cpu_div
  import cpuclk_pkg::*;
#(
  parameter int FAST_DIV    = 5,
  parameter int SLOW_DIV    = 10,
  parameter int FETCH_EXTRA = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  speed_e speed_i,
  input  logic   fetch_i,
  output logic   ce_o,
  output logic   sq_o
);

  localparam int STRETCH_DIV = FAST_DIV + FETCH_EXTRA;
  localparam int MAX_DIV     = (SLOW_DIV > STRETCH_DIV) ? SLOW_DIV : STRETCH_DIV;
  localparam int CW          = $clog2(MAX_DIV + 1);
  localparam logic [CW-1:0] L_FAST    = CW'(FAST_DIV);
  localparam logic [CW-1:0] L_SLOW    = CW'(SLOW_DIV);
  localparam logic [CW-1:0] L_STRETCH = CW'(STRETCH_DIV);

  logic [CW-1:0] cnt_q, len_q;
  logic [CW-1:0] cnt_n, len_n, len_pick;
  logic          wrap;

  // Length for a period that starts at this edge
  always_comb begin
    if (speed_i == SPEED_SLOW) len_pick = L_SLOW;
    else if (fetch_i)          len_pick = L_STRETCH;
    else                       len_pick = L_FAST;
  end

  always_comb begin
    wrap  = (cnt_q == len_q - 1'b1);
    cnt_n = wrap ? '0 : cnt_q + 1'b1;
    len_n = wrap ? len_pick : len_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len_q <= L_SLOW;
      ce_o  <= 1'b0;
      sq_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      len_q <= len_n;
      ce_o  <= (cnt_n == '0);
      sq_o  <= (cnt_n < (len_n >> 1));
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < len_q); // R5
  AST_LEN_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(len_q)); // R5
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (len_q == L_SLOW) || (len_q == L_FAST) || (len_q == L_STRETCH)); // R2
  AST_CPU_CE_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
    ce_o |-> sq_o); // R6
  AST_CPU_CE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ce_o |=> !ce_o); // R6

endmodule

// File: rtl/pix_mux.sv
module pix_mux
  import cpuclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    int_ce_i,
  input  logic    ext_ce_i,
  input  pixsrc_e req_i,
  output logic    ce_o,
  output pixsrc_e src_o
);

  logic cur_ce;

  always_comb begin
    cur_ce = (src_o == PIXSRC_EXT) ? ext_ce_i : int_ce_i;
  end

  // The selection moves only on a pulse of the active source, which still goes out
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_o  <= 1'b0;
      src_o <= PIXSRC_INT;
    end else begin
      ce_o <= cur_ce;
      if (cur_ce) src_o <= req_i;
    end
  end

  AST_PIX_SWITCH_SAFE: assert property (@(posedge clk) disable iff (rst)
    !cur_ce |=> $stable(src_o)); // R10
  AST_PIX_FOLLOW_EXT: assert property (@(posedge clk) disable iff (rst)
    (src_o == PIXSRC_EXT) |=> (ce_o == $past(ext_ce_i))); // R9

endmodule

// File: rtl/cpuclk_gen.sv
module cpuclk_gen
  import cpuclk_pkg::*;
#(
  parameter int FAST_DIV    = 5,
  parameter int SLOW_DIV    = 10,
  parameter int FETCH_EXTRA = 1,
  parameter int SER_DIV     = 4,
  parameter int PIX_DIV     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_sel_i,
  input  logic fetch_i,
  input  logic pix_ext_req_i,
  input  logic ext_pix_en_i,
  output logic cpu_clk_o,
  output logic cpu_ce_o,
  output logic ser_clk_o,
  output logic ser_ce_o,
  output logic pix_ce_o,
  output logic pix_src_o
);

  speed_e  speed;
  pixsrc_e pix_req;
  pixsrc_e pix_src;
  logic    pix_int_ce;
  logic    pix_int_sq;

  assign speed     = speed_e'(fast_sel_i);
  assign pix_req   = pixsrc_e'(pix_ext_req_i);
  assign pix_src_o = pix_src;

  cpu_div #(
    .FAST_DIV    (FAST_DIV),
    .SLOW_DIV    (SLOW_DIV),
    .FETCH_EXTRA (FETCH_EXTRA)
  ) u_cpu_div (
    .clk     (clk),
    .rst     (rst),
    .speed_i (speed),
    .fetch_i (fetch_i),
    .ce_o    (cpu_ce_o),
    .sq_o    (cpu_clk_o)
  );

  fixed_div #(.DIV(SER_DIV)) u_ser_div (
    .clk  (clk),
    .rst  (rst),
    .ce_o (ser_ce_o),
    .sq_o (ser_clk_o)
  );

  fixed_div #(.DIV(PIX_DIV)) u_pix_div (
    .clk  (clk),
    .rst  (rst),
    .ce_o (pix_int_ce),
    .sq_o (pix_int_sq)
  );

  pix_mux u_pix_mux (
    .clk      (clk),
    .rst      (rst),
    .int_ce_i (pix_int_ce),
    .ext_ce_i (ext_pix_en_i),
    .req_i    (pix_req),
    .ce_o     (pix_ce_o),
    .src_o    (pix_src)
  );

  AST_PIX_INT_CE_HIGH: assert property (@(posedge clk) disable iff (rst)
    pix_int_ce |-> pix_int_sq); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!cpu_ce_o && !ser_ce_o && !pix_ce_o)); // R1

endmodule

// File: tb/cpuclk_gen_bench.sv
module cpuclk_gen_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fast_sel = 1'b0, fetch = 1'b0, pix_req = 1'b0, ext_en = 1'b0;
  logic cpu_clk, cpu_ce, ser_clk, ser_ce, pix_ce, pix_src;

  int n_vec = 0, n_bad = 0, n = 0;
  bit done = 0;

  // CPU period model
  bit in_period = 0, seen_first = 0;
  int exp_len = 10, cyc = 0, hi_cnt = 0;
  // pixel selection model
  bit sel_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuclk_gen u_cpuclk_gen (
    .clk(clk), .rst(rst), .fast_sel_i(fast_sel), .fetch_i(fetch),
    .pix_ext_req_i(pix_req), .ext_pix_en_i(ext_en),
    .cpu_clk_o(cpu_clk), .cpu_ce_o(cpu_ce), .ser_clk_o(ser_clk),
    .ser_ce_o(ser_ce), .pix_ce_o(pix_ce), .pix_src_o(pix_src)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, n, act, exp);
    end
  endtask

  function automatic int len_for(bit f, bit m);
    if (!f) return 10;
    return m ? 6 : 5;
  endfunction

  function automatic string tag_for(int l);
    if (l == 10) return "R2";
    if (l == 6)  return "R4";
    return "R3";
  endfunction

  task automatic check_all();
    bit exp_pix;
    // CPU clock
    if (cpu_ce) begin
      if (!seen_first) begin
        chk(n == 10, "R1 first cpu strobe edge", n, 10);
        seen_first = 1;
      end
      chk(cpu_clk == 1'b1, "R6 strobe on high cycle", cpu_clk, 1);
      if (in_period) begin
        chk(cyc == exp_len, {tag_for(exp_len), "/R5 period length"}, cyc, exp_len);
        chk(hi_cnt == exp_len / 2, {tag_for(exp_len), " high cycles"}, hi_cnt, exp_len / 2);
      end
      exp_len   = len_for(fast_sel, fetch);
      in_period = 1;
      cyc       = 1;
      hi_cnt    = cpu_clk ? 1 : 0;
    end else begin
      cyc++;
      if (cpu_clk) hi_cnt++;
      if (in_period && cyc > exp_len) chk(0, "R6 missing cpu strobe", cyc, exp_len);
    end
    // serial reference
    chk(ser_ce == (n % 4 == 0), "R7 serial strobe", ser_ce, n % 4 == 0);
    chk(ser_clk == (n % 4 < 2), "R7 serial square", ser_clk, n % 4 < 2);
    // pixel path
    exp_pix = sel_m ? ext_en : (n >= 3 && n % 2 == 1);
    if (sel_m) chk(pix_ce == exp_pix, "R9 external pixel strobe", pix_ce, exp_pix);
    else       chk(pix_ce == exp_pix, "R8 internal pixel strobe", pix_ce, exp_pix);
    if (exp_pix) sel_m = pix_req;
    chk(pix_src == sel_m, "R10 pixel source", pix_src, sel_m);
  endtask

  task automatic step();
    @(posedge clk);
    n++;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4051));
    repeat (3) @(negedge clk);
    chk({cpu_clk, cpu_ce, ser_clk, ser_ce, pix_ce, pix_src} == 6'b0, "R1 reset outputs",
        {cpu_clk, cpu_ce, ser_clk, ser_ce, pix_ce, pix_src}, 0);
    // fast request during reset must not shorten the first period
    fast_sel = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    fast_sel = 1'b0;
    n = 0;
    // slow
    repeat (40) step();
    // fast, no fetch
    fast_sel = 1'b1;
    repeat (40) step();
    // fast with fetch held
    fetch = 1'b1;
    repeat (40) step();
    // fetch toggled every cycle mid-period (R5)
    for (int i = 0; i < 40; i++) begin
      step();
      fetch = ~fetch;
    end
    // move the pixel path to the external source and back
    pix_req = 1'b1;
    for (int i = 0; i < 60; i++) begin
      step();
      ext_en = (i % 3 != 0);
    end
    pix_req = 1'b0;
    for (int i = 0; i < 30; i++) begin
      step();
      ext_en = (i % 5 == 2);
    end
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      step();
      if ($urandom_range(49) == 0) fast_sel = ~fast_sel;
      fetch  = ($urandom_range(2) == 0);
      if ($urandom_range(19) == 0) pix_req = ~pix_req;
      ext_en = ($urandom_range(7) < 5);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule